// File: doc/BRIEF.md
# Snooping Cache Coherence Controller with Selectable Write Policy

This block sits between one processor and a small direct-mapped cache. It keeps that cache coherent with the caches of other processors that share a single broadcast bus. A configuration input selects one of three write policies. With write-through plus update, every store goes to memory and its new data is broadcast. With write-through plus invalidate, every store goes to memory and only a kill notice is broadcast. With write-back, a store first claims exclusive ownership of the line, and a modified line reaches memory only when it is evicted or when another agent claims it.

The controller also watches every transaction on the shared bus. Messages from other agents patch or drop matching lines in the local cache. Messages that carry the controller's own source number are ignored. Before it may drive the bus, the controller raises a request and waits for a grant from an arbiter outside the block. While it waits, the processor is stalled. Misses allocate a line: the controller fetches the word through a memory read port with one cycle of latency, after first writing back a dirty victim when the policy is write-back.

Top module: `swp_snoop_ctrl`

## Requirements
- R1: After reset the processor ready output, bus request, memory write enable, memory read enable and outgoing bus message are all low. Every cache line is invalid, so the first load of any address reads memory.
- R2: A load that hits returns the cached word with `cpu_ready` high for exactly one cycle and causes no memory read.
- R3: A load that misses raises `mem_re` once with the requested address, installs the returned word, and returns it. A later load of the same address hits.
- R4: Policy 0 (write-through, update) is selected when `cfg_mode`=2'b00. A store raises `bus_req` and stalls the processor until `bus_gnt`. In the granted cycle the bus carries message 2'b01 with the store's address and data, and memory is written with the same address and data in that same cycle.
- R5: Policy 1 (write-through, invalidate) is selected when `cfg_mode`=2'b01. A store sends message 2'b10 in the granted cycle together with the memory write, and the local copy holds the new data.
- R6: Policy 2 (write-back) is selected when `cfg_mode`=2'b10. A store to a line not held exclusively sends ownership request 2'b11 and performs no memory write. The line then becomes exclusive and modified, and further stores to it make no bus or memory traffic.
- R7: In write-back policy, a miss whose victim line is modified first writes the victim's address and data to memory, then fetches the new word.
- R8: An update message (2'b01) from another source whose address matches a valid line replaces that line's data. The next load returns the new data without reading memory.
- R9: An invalidate (2'b10) or ownership request (2'b11) from another source whose address matches a valid line invalidates it. The next load of that address misses and reads memory.
- R10: When an invalidate or ownership request from another source hits a modified line, that line's address and data are written to memory in the same cycle.
- R11: Messages whose source equals the controller's own identifier are ignored. So are messages whose address maps to the same line but carries a different tag.
- R12: A store that misses allocates the line from memory first and then proceeds as a store hit under the current policy.
- R13: Bus message codes are 2'b00 idle, 2'b01 update, 2'b10 invalidate and 2'b11 ownership request. The controller only drives a non-idle code while both requested and granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Write policy: 0 update, 1 invalidate, 2 write-back |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid with ready |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_re | output | 1 | Memory read enable |
| mem_raddr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Read data, one cycle after mem_re |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Grant from the external arbiter |
| bus_out_type | output | 2 | Outgoing message code |
| bus_out_addr | output | ADDR_W | Outgoing message address |
| bus_out_data | output | DATA_W | Outgoing message data (zero for ownership) |
| bus_out_src | output | SRC_W | Own source number |
| bus_in_type | input | 2 | Snooped message code |
| bus_in_addr | input | ADDR_W | Snooped message address |
| bus_in_data | input | DATA_W | Snooped message data |
| bus_in_src | input | SRC_W | Snooped message source |

## Verification
Some rules are checked on every cycle. A message goes out only under grant. The message code matches the selected policy. Each write-through broadcast is paired with a matching memory write. Ownership requests never come with a memory write. Ready is a single-cycle pulse. Other behaviour shows up only through bench scenarios: hits versus misses (counted at the memory read port), data patched or dropped by snooped traffic, victim write-back order, and flushes on a remote claim. A random mix of local loads, stores and remote writes under each policy compares every load against the last value written anywhere.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [1:0] {
        MSG_IDLE = 2'b00,
        MSG_UPD  = 2'b01,
        MSG_INV  = 2'b10,
        MSG_OWN  = 2'b11
    } msg_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_FILL_W,
        ST_BUS,
        ST_DONE
    } cst_e;

    // policy select: bit 1 set means write-back, else bit 0 picks invalidate over update
    function automatic msg_e store_msg(input logic [1:0] mode);
        if (mode[1]) return MSG_OWN;
        if (mode[0]) return MSG_INV;
        return MSG_UPD;
    endfunction

endpackage

// File: rtl/swp_snoop_decode.sv
module swp_snoop_decode
    import swp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int SRC_W  = 2,
    parameter int MY_ID  = 1
) (
    input  logic [1:0]              in_type,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic [SRC_W-1:0]        in_src,
    output logic                    snp_upd,
    output logic                    snp_kill,
    output logic [IDX_W-1:0]        snp_idx,
    output logic [ADDR_W-IDX_W-1:0] snp_tag
);
    logic foreign;

    always_comb begin
        foreign  = (in_src != SRC_W'(MY_ID));
        snp_upd  = foreign && (in_type == MSG_UPD);
        snp_kill = foreign && ((in_type == MSG_INV) || (in_type == MSG_OWN));
        snp_idx  = in_addr[IDX_W-1:0];
        snp_tag  = in_addr[ADDR_W-1:IDX_W];
    end

endmodule

// File: rtl/swp_bus_drive.sv
module swp_bus_drive
    import swp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int SRC_W  = 2,
    parameter int MY_ID  = 1
) (
    input  logic              active,
    input  logic              gnt,
    input  msg_e              kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              req,
    output logic              fire,
    output logic [1:0]        out_type,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [SRC_W-1:0]  out_src
);
    always_comb begin
        req      = active;
        fire     = active && gnt;
        out_type = fire ? kind : MSG_IDLE;
        out_addr = fire ? addr : '0;
        out_data = (fire && (kind != MSG_OWN)) ? data : '0;
        out_src  = SRC_W'(MY_ID);
    end

endmodule

// File: rtl/swp_snoop_ctrl.sv
module swp_snoop_ctrl
    import swp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int LINES  = 4,
    parameter int SRC_W  = 2,
    parameter int MY_ID  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_out_type,
    output logic [ADDR_W-1:0] bus_out_addr,
    output logic [DATA_W-1:0] bus_out_data,
    output logic [SRC_W-1:0]  bus_out_src,
    input  logic [1:0]        bus_in_type,
    input  logic [ADDR_W-1:0] bus_in_addr,
    input  logic [DATA_W-1:0] bus_in_data,
    input  logic [SRC_W-1:0]  bus_in_src
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             excl;
        logic [TAG_W-1:0] tag;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        cst_e                   st;
        line_t [LINES-1:0]      lines;
        logic [DATA_W-1:0]      rdata;
    } regs_t;

    regs_t q, d;

    logic              is_wb;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    line_t             cur;
    line_t             fl;
    logic              hit;
    logic              snp_upd, snp_kill;
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    logic [LINES-1:0]  snp_hit;
    logic [LINES-1:0]  flush_vec;
    logic              flush_any;
    logic              local_kill;
    logic              bus_fire;
    msg_e              st_kind;

    assign is_wb = cfg_mode[1];
    assign idx   = cpu_addr[IDX_W-1:0];
    assign tag   = cpu_addr[ADDR_W-1:IDX_W];
    assign cur   = q.lines[idx];
    assign fl    = q.lines[snp_idx];
    assign hit   = cur.valid && (cur.tag == tag);
    assign st_kind = store_msg(cfg_mode);

    swp_snoop_decode #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SRC_W(SRC_W), .MY_ID(MY_ID)
    ) u_decode (
        .in_type (bus_in_type),
        .in_addr (bus_in_addr),
        .in_src  (bus_in_src),
        .snp_upd (snp_upd),
        .snp_kill(snp_kill),
        .snp_idx (snp_idx),
        .snp_tag (snp_tag)
    );

    swp_bus_drive #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .MY_ID(MY_ID)
    ) u_drive (
        .active  (q.st == ST_BUS),
        .gnt     (bus_gnt),
        .kind    (st_kind),
        .addr    (cpu_addr),
        .data    (cpu_wdata),
        .req     (bus_req),
        .fire    (bus_fire),
        .out_type(bus_out_type),
        .out_addr(bus_out_addr),
        .out_data(bus_out_data),
        .out_src (bus_out_src)
    );

    // per-line snoop match and flush demand
    for (genvar gi = 0; gi < LINES; gi++) begin : g_snoop
        assign snp_hit[gi] = (snp_upd || snp_kill) && q.lines[gi].valid &&
                             (q.lines[gi].tag == snp_tag) && (snp_idx == IDX_W'(gi));
        assign flush_vec[gi] = snp_kill && snp_hit[gi] && q.lines[gi].dirty && is_wb;
    end

    assign flush_any  = |flush_vec;
    assign local_kill = snp_kill && snp_hit[idx];

    // memory write port: remote-claim flush first, then victim, then write-through
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = cpu_addr;
        mem_wdata = cpu_wdata;
        if (flush_any) begin
            mem_we    = 1'b1;
            mem_waddr = {fl.tag, snp_idx};
            mem_wdata = fl.data;
        end else if (q.st == ST_WBACK && cur.valid && cur.dirty) begin
            mem_we    = 1'b1;
            mem_waddr = {cur.tag, idx};
            mem_wdata = cur.data;
        end else if (bus_fire && !is_wb) begin
            mem_we = 1'b1;
        end
    end

    assign mem_re    = (q.st == ST_FILL);
    assign mem_raddr = cpu_addr;
    assign cpu_ready = (q.st == ST_DONE);
    assign cpu_rdata = q.rdata;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (cpu_req && !snp_hit[idx]) begin
                    if (hit) begin
                        if (!cpu_we) begin
                            d.rdata = cur.data;
                            d.st    = ST_DONE;
                        end else if (is_wb && cur.excl) begin
                            d.lines[idx].data  = cpu_wdata;
                            d.lines[idx].dirty = 1'b1;
                            d.st               = ST_DONE;
                        end else begin
                            d.st = ST_BUS;
                        end
                    end else if (is_wb && cur.valid && cur.dirty) begin
                        d.st = ST_WBACK;
                    end else begin
                        d.st = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                if (!flush_any) begin
                    d.lines[idx].valid = 1'b0;
                    d.lines[idx].dirty = 1'b0;
                    d.lines[idx].excl  = 1'b0;
                    d.st               = ST_FILL;
                end
            end
            ST_FILL: begin
                d.st = ST_FILL_W;
            end
            ST_FILL_W: begin
                d.lines[idx].valid = 1'b1;
                d.lines[idx].dirty = 1'b0;
                d.lines[idx].excl  = 1'b0;
                d.lines[idx].tag   = tag;
                d.lines[idx].data  = mem_rdata;
                d.st               = ST_IDLE;
            end
            ST_BUS: begin
                if (local_kill) begin
                    d.st = ST_IDLE;
                end else if (bus_fire) begin
                    d.lines[idx].data = cpu_wdata;
                    if (is_wb) begin
                        d.lines[idx].excl  = 1'b1;
                        d.lines[idx].dirty = 1'b1;
                    end
                    d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        // snooped traffic from other agents; a line being refilled is superseded
        for (int i = 0; i < LINES; i++) begin
            if (snp_hit[i] && !(q.st == ST_FILL_W && IDX_W'(i) == idx)) begin
                if (snp_upd) d.lines[i].data = bus_in_data;
                if (snp_kill) begin
                    d.lines[i].valid = 1'b0;
                    d.lines[i].dirty = 1'b0;
                    d.lines[i].excl  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.lines <= '0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/swp_ctrl_checker.sv
module swp_ctrl_checker #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_out_type,
    input logic [ADDR_W-1:0] bus_out_addr,
    input logic [DATA_W-1:0] bus_out_data,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_re
);
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R2

    AST_ONE_FILL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re); // R3

    AST_WT_MEM_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode[1] && bus_out_type != 2'b00) |->
        (mem_we && mem_waddr == bus_out_addr && mem_wdata == bus_out_data)); // R4

    AST_UPD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b00 && bus_out_type != 2'b00) |-> bus_out_type == 2'b01); // R4

    AST_INV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b01 && bus_out_type != 2'b00) |-> bus_out_type == 2'b10); // R5

    AST_OWN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode[1] && bus_out_type != 2'b00) |-> (bus_out_type == 2'b11 && !mem_we)); // R6

    AST_SEND_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_out_type != 2'b00) |-> (bus_req && bus_gnt)); // R13

    AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |-> !cpu_ready); // R4

endmodule

bind swp_snoop_ctrl swp_ctrl_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .cpu_ready   (cpu_ready),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_out_type(bus_out_type),
    .bus_out_addr(bus_out_addr),
    .bus_out_data(bus_out_data),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_wdata   (mem_wdata),
    .mem_re      (mem_re)
);

// File: tb/swp_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module swp_snoop_ctrl_bench;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int SW = 2;
    localparam int ME = 1;
    localparam int OTH = 2;
    localparam int MSZ = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          mem_we, mem_re;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          bus_req, bus_gnt;
    logic [1:0]    bus_out_type, bus_in_type;
    logic [AW-1:0] bus_out_addr, bus_in_addr;
    logic [DW-1:0] bus_out_data, bus_in_data;
    logic [SW-1:0] bus_out_src, bus_in_src;

    logic [1:0]    oth_type = 2'b00;
    logic [AW-1:0] oth_addr = '0;
    logic [DW-1:0] oth_data = '0;
    logic [SW-1:0] oth_src = SW'(OTH);
    logic          oth_we = 1'b0;
    logic [AW-1:0] oth_waddr = '0;
    logic [DW-1:0] oth_wdata = '0;
    logic          do_init = 1'b0;

    logic [DW-1:0] mem  [MSZ];
    logic [DW-1:0] gold [MSZ];
    int unsigned   rd_cnt = 0, wr_cnt = 0, msg_cnt = 0;
    logic [AW-1:0] last_wa = '0, last_ba = '0;
    logic [DW-1:0] last_wd = '0, last_bd = '0;
    logic [1:0]    last_bt = '0;
    logic          last_mw = 1'b0;
    int            total = 0, bad = 0;
    bit            finished = 0;
    logic [DW-1:0] op_res;

    swp_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(4), .SRC_W(SW), .MY_ID(ME)) u_swp_snoop_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_out_type(bus_out_type), .bus_out_addr(bus_out_addr),
        .bus_out_data(bus_out_data), .bus_out_src(bus_out_src),
        .bus_in_type(bus_in_type), .bus_in_addr(bus_in_addr),
        .bus_in_data(bus_in_data), .bus_in_src(bus_in_src)
    );

    // other agent has fixed priority over the controller
    assign bus_gnt     = bus_req && (oth_type == 2'b00);
    assign bus_in_type = (bus_out_type != 2'b00) ? bus_out_type : oth_type;
    assign bus_in_addr = (bus_out_type != 2'b00) ? bus_out_addr : oth_addr;
    assign bus_in_data = (bus_out_type != 2'b00) ? bus_out_data : oth_data;
    assign bus_in_src  = (bus_out_type != 2'b00) ? bus_out_src  : oth_src;

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(32'hA000 ^ (a * 73));
    endfunction

    always @(posedge clk) begin
        if (do_init) begin
            for (int i = 0; i < MSZ; i++) mem[i] <= pat(i);
        end else begin
            if (mem_we) begin
                mem[mem_waddr] <= mem_wdata;
                wr_cnt  <= wr_cnt + 1;
                last_wa <= mem_waddr;
                last_wd <= mem_wdata;
            end
            if (oth_we) mem[oth_waddr] <= oth_wdata;
        end
        if (mem_re) begin
            mem_rdata <= mem[mem_raddr];
            rd_cnt    <= rd_cnt + 1;
        end
        if (bus_out_type != 2'b00) begin
            msg_cnt <= msg_cnt + 1;
            last_bt <= bus_out_type;
            last_ba <= bus_out_addr;
            last_bd <= bus_out_data;
            last_mw <= mem_we && (mem_waddr == bus_out_addr) && (mem_wdata == bus_out_data);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; cfg_mode = m; cpu_req = 1'b0; oth_type = 2'b00; oth_we = 1'b0;
        do_init = 1'b1;
        repeat (3) @(negedge clk);
        do_init = 1'b0;
        for (int i = 0; i < MSZ; i++) gold[i] = pat(i);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        int n = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ready && n < 200);
        if (n >= 200) chk("R2 op timeout", 32'(n), 32'(0));
        op_res  = cpu_rdata;
        cpu_req = 1'b0;
        if (we) gold[a] = wd;
    endtask

    task automatic oth_msg(input logic [1:0] t, input logic [AW-1:0] a,
                           input logic [DW-1:0] v, input logic [SW-1:0] s);
        oth_type = t; oth_addr = a; oth_data = v; oth_src = s;
        @(negedge clk);
        oth_type = 2'b00; oth_src = SW'(OTH);
    endtask

    task automatic oth_mem(input logic [AW-1:0] a, input logic [DW-1:0] v);
        oth_we = 1'b1; oth_waddr = a; oth_wdata = v;
        @(negedge clk);
        oth_we = 1'b0;
        gold[a] = v;
    endtask

    task automatic oth_write(input logic [AW-1:0] a, input logic [DW-1:0] v);
        logic [1:0] t;
        t = cfg_mode[1] ? 2'b11 : (cfg_mode[0] ? 2'b10 : 2'b01);
        oth_msg(t, a, v, SW'(OTH));
        oth_mem(a, v);
    endtask

    task automatic random_phase(input logic [1:0] m, input string tag);
        do_reset(m);
        for (int k = 0; k < 250; k++) begin
            int unsigned r;
            logic [AW-1:0] a;
            logic [DW-1:0] v;
            r = $urandom % 10;
            a = AW'($urandom % 16);
            v = DW'($urandom);
            if (r < 5) begin
                cpu_op(1'b0, a, '0);
                chk(tag, 32'(op_res), 32'(gold[a]));
            end else if (r < 8) begin
                cpu_op(1'b1, a, v);
            end else begin
                oth_write(a, v);
            end
        end
    endtask

    initial begin
        int unsigned r0, w0, m0;
        void'($urandom(32'd1357));

        // ---------------- write-through, update ----------------
        do_reset(2'b00);
        chk("R1 ready", 32'(cpu_ready), 0);
        chk("R1 bus_req", 32'(bus_req), 0);
        chk("R1 bus type", 32'(bus_out_type), 0);
        chk("R1 mem_we", 32'(mem_we), 0);
        chk("R1 mem_re", 32'(mem_re), 0);
        r0 = rd_cnt;
        cpu_op(1'b0, 6'd5, '0);
        chk("R3 miss data", 32'(op_res), 32'(pat(5)));
        chk("R3 miss reads memory", rd_cnt, r0 + 1);
        chk("R1 first load missed", rd_cnt, r0 + 1);
        cpu_op(1'b0, 6'd5, '0);
        chk("R2 hit data", 32'(op_res), 32'(pat(5)));
        chk("R2 hit no read", rd_cnt, r0 + 1);
        @(negedge clk);
        chk("R2 ready single cycle", 32'(cpu_ready), 0);

        // stall while the other agent holds the bus (R4)
        m0 = msg_cnt; w0 = wr_cnt;
        oth_type = 2'b10; oth_addr = 6'd40; oth_src = SW'(OTH);
        fork
            cpu_op(1'b1, 6'd5, 16'h1234);
        join_none
        repeat (4) @(negedge clk);
        chk("R4 request while stalled", 32'(bus_req), 1);
        chk("R4 no message before grant", msg_cnt, m0);
        chk("R4 no memory write before grant", wr_cnt, w0);
        chk("R4 no ready before grant", 32'(cpu_ready), 0);
        oth_type = 2'b00;
        wait fork;
        chk("R4 message code", 32'(last_bt), 32'h1);
        chk("R4 message addr", 32'(last_ba), 32'd5);
        chk("R4 message data", 32'(last_bd), 32'h1234);
        chk("R4 memory written same cycle", 32'(last_mw), 1);
        chk("R4 memory content", 32'(mem[5]), 32'h1234);
        r0 = rd_cnt;
        cpu_op(1'b0, 6'd5, '0);
        chk("R4 local copy", 32'(op_res), 32'h1234);

        // remote update (R8)
        oth_msg(2'b01, 6'd5, 16'h5555, SW'(OTH));
        oth_mem(6'd5, 16'h5555);
        cpu_op(1'b0, 6'd5, '0);
        chk("R8 patched data", 32'(op_res), 32'h5555);
        chk("R8 no memory read", rd_cnt, r0);

        // own source and foreign tag are ignored (R11)
        oth_msg(2'b10, 6'd5, '0, SW'(ME));
        cpu_op(1'b0, 6'd5, '0);
        chk("R11 own source ignored", rd_cnt, r0);
        oth_msg(2'b10, 6'd9, '0, SW'(OTH));
        cpu_op(1'b0, 6'd5, '0);
        chk("R11 other tag ignored", rd_cnt, r0);
        chk("R11 data kept", 32'(op_res), 32'h5555);

        // store miss allocates (R12)
        cpu_op(1'b1, 6'd20, 16'h2020);
        chk("R12 allocate read", rd_cnt, r0 + 1);
        chk("R12 then broadcast", 32'(last_ba), 32'd20);
        cpu_op(1'b0, 6'd20, '0);
        chk("R12 stored value", 32'(op_res), 32'h2020);
        chk("R12 hit after allocate", rd_cnt, r0 + 1);

        // ---------------- write-through, invalidate ----------------
        do_reset(2'b01);
        r0 = rd_cnt;
        cpu_op(1'b1, 6'd7, 16'h0777);
        chk("R12 allocate in invalidate mode", rd_cnt, r0 + 1);
        chk("R5 message code", 32'(last_bt), 32'h2);
        chk("R5 memory written same cycle", 32'(last_mw), 1);
        cpu_op(1'b0, 6'd7, '0);
        chk("R5 local copy", 32'(op_res), 32'h0777);
        chk("R5 local hit", rd_cnt, r0 + 1);
        oth_msg(2'b10, 6'd7, '0, SW'(OTH));
        oth_mem(6'd7, 16'h0BBB);
        cpu_op(1'b0, 6'd7, '0);
        chk("R9 refetch after invalidate", rd_cnt, r0 + 2);
        chk("R9 fresh data", 32'(op_res), 32'h0BBB);

        // ---------------- write-back ----------------
        do_reset(2'b10);
        cpu_op(1'b0, 6'd6, '0);
        w0 = wr_cnt; r0 = rd_cnt;
        cpu_op(1'b1, 6'd6, 16'h6666);
        chk("R6 ownership code", 32'(last_bt), 32'h3);
        chk("R6 ownership addr", 32'(last_ba), 32'd6);
        chk("R6 no memory write", wr_cnt, w0);
        m0 = msg_cnt;
        cpu_op(1'b1, 6'd6, 16'h6667);
        chk("R6 exclusive store silent on bus", msg_cnt, m0);
        chk("R6 exclusive store no memory write", wr_cnt, w0);
        cpu_op(1'b0, 6'd6, '0);
        chk("R6 modified data", 32'(op_res), 32'h6667);
        chk("R6 hit", rd_cnt, r0);
        cpu_op(1'b0, 6'd14, '0);
        chk("R7 victim written", wr_cnt, w0 + 1);
        chk("R7 victim addr", 32'(last_wa), 32'd6);
        chk("R7 victim data", 32'(last_wd), 32'h6667);
        chk("R7 memory holds victim", 32'(mem[6]), 32'h6667);
        chk("R7 new line data", 32'(op_res), 32'(pat(14)));
        cpu_op(1'b1, 6'd14, 16'h1414);
        w0 = wr_cnt; r0 = rd_cnt;
        oth_msg(2'b11, 6'd14, '0, SW'(OTH));
        chk("R10 flush on remote claim", wr_cnt, w0 + 1);
        chk("R10 flush addr", 32'(last_wa), 32'd14);
        chk("R10 flush data", 32'(last_wd), 32'h1414);
        cpu_op(1'b0, 6'd14, '0);
        chk("R9 miss after ownership claim", rd_cnt, r0 + 1);
        chk("R9 data from memory", 32'(op_res), 32'h1414);

        // ---------------- random mixes ----------------
        random_phase(2'b00, "R8 random update mode");
        random_phase(2'b01, "R9 random invalidate mode");
        random_phase(2'b10, "R10 random write-back mode");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule